// File: doc/BRIEF.md
# Thermal Status Flags and Alert Generator

This block holds an 8-bit thermal status word for a fan controller. It compares the local, remote and active-control temperatures against four programmable limits and samples an external active-low thermal request. Each result lands in a flag bit that stays set until it is cleared. The flags differ in how they clear and re-arm. Some clear when this status word is read. One clears only when a companion status word is read, and then waits for 5 °C of hysteresis before it can set again. The critical flags set again on the next monitoring cycle if their condition still holds.

The flags drive three active-low outputs: a thermal pin, an over-temperature pin and an alert line. The alert line combines the maskable sources, each gated by its own enable, with the critical sources, which have no enable. Temperature conversion and the serial bus slave are outside this block. Their results arrive as plain ports: 8-bit two's-complement temperatures, a monitoring-cycle strobe and single-cycle read strobes.

Top module: `therm_status_reg`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0x00 and `therm_pin_n`, `ovr_pin_n` and `alert_n` are 1. Bits 2..0 of `rd_data` always read 0.
- R2: Bit 7 sets when `ext_therm_n` is low. The input passes through a two-stage synchronizer, so the bit appears on the third rising edge after the input falls. The bit stays set after the input returns high.
- R3: A pulse on `rd_self` clears bit 7. A pulse on `rd_peer` leaves it unchanged.
- R4: On a `mon_tick`, bit 6 sets when `temp_local` is strictly greater than `lim_therm`. Equality does not set it. While bit 6 is 1, `therm_pin_n` is 0.
- R5: A pulse on `rd_peer` clears bit 6. A pulse on `rd_self` does not clear it.
- R6: Once bit 6 has been cleared by `rd_peer`, it stays 0 on over-limit ticks. It can set again only after a tick with `temp_local <= lim_therm - 5`. A later over-limit tick then sets it.
- R7: On a `mon_tick`, bit 5 sets when `temp_active <= lim_passive`. `rd_self` clears it, and it sets again on the next tick if the condition still holds.
- R8: On a `mon_tick`, bit 4 sets when `temp_local >= lim_crit_local`, and bit 3 sets when `temp_remote >= lim_crit_remote`. While either bit is 1, `ovr_pin_n` is 0.
- R9: `rd_self` clears bits 4 and 3. Each sets again on the next tick if its condition persists, and stays 0 once the condition is gone.
- R10: Bits 6..3 change to 1 only on a clock where `mon_tick` is 1.
- R11: `alert_n` is the inverse of (bit6 AND `en_therm_irq`) OR (bit5 AND `en_passive_irq`) OR bit4 OR bit3. Bit 7 does not drive the alert. An enable change takes effect one clock later.
- R12: When a flag's set condition and its clearing read occur in the same clock, the flag stays 1. During the read clock, `rd_data` shows the value held before any clear.
- R13: All comparisons treat temperatures and limits as signed two's complement. For example, -20 is below a limit of 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_tick | input | 1 | Monitoring-cycle strobe; comparisons are taken on it |
| temp_local | input | 8 | Local temperature, signed °C |
| temp_remote | input | 8 | Remote temperature, signed °C |
| temp_active | input | 8 | Active-control temperature, signed °C |
| lim_therm | input | 8 | Local thermal limit for bit 6 |
| lim_passive | input | 8 | Passive-cooling threshold for bit 5 |
| lim_crit_local | input | 8 | Local critical limit for bit 4 |
| lim_crit_remote | input | 8 | Remote critical limit for bit 3 |
| ext_therm_n | input | 1 | External thermal request, active low, asynchronous |
| en_therm_irq | input | 1 | Alert enable for bit 6 |
| en_passive_irq | input | 1 | Alert enable for bit 5 |
| rd_self | input | 1 | Single-cycle read strobe for this status word |
| rd_peer | input | 1 | Single-cycle read strobe for the companion status word |
| rd_data | output | 8 | Status word |
| therm_pin_n | output | 1 | Thermal pin drive, active low |
| ovr_pin_n | output | 1 | Over-temperature pin, active low |
| alert_n | output | 1 | Alert line, active low |

## Verification
The assertions assume that `rd_self`, `rd_peer` and `mon_tick` are synchronous to `clk`. The clear-after-read properties treat a read clock with no strobe as one where no flag can set. The bench therefore drives every input on the falling edge. It holds temperatures and limits steady across each strobe. Outside the intended test it keeps the limits at values where the unrelated flags cannot trigger, so each read or tick affects only the flags under test.

// File: rtl/therm_stat_pkg.sv
package therm_stat_pkg;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_GE = 2'd1,
    CMP_LE = 2'd2
  } cmp_mode_e;

  // bit positions of the status word
  localparam int BIT_EXT     = 7;
  localparam int BIT_OVERLIM = 6;
  localparam int BIT_PASSIVE = 5;
  localparam int BIT_CRITLOC = 4;
  localparam int BIT_CRITREM = 3;

  localparam int STAT_W  = 8;
  localparam int NUM_CMP = 4;

  // comparator slot -> comparison kind
  function automatic cmp_mode_e slot_mode(input int slot);
    case (slot)
      0:       return CMP_GT;  // over local thermal limit
      1:       return CMP_LE;  // at or below passive threshold
      default: return CMP_GE;  // critical limits
    endcase
  endfunction

  // comparator slot -> status bit it feeds
  function automatic int slot_bit(input int slot);
    case (slot)
      0:       return BIT_OVERLIM;
      1:       return BIT_PASSIVE;
      2:       return BIT_CRITLOC;
      default: return BIT_CRITREM;
    endcase
  endfunction

endpackage

// File: rtl/therm_cmp.sv
module therm_cmp
  import therm_stat_pkg::*;
#(
  parameter int        W    = 8,
  parameter cmp_mode_e MODE = CMP_GE
) (
  input  logic signed [W-1:0] val_i,
  input  logic signed [W-1:0] lim_i,
  output logic                hit_o
);

  generate
    if (MODE == CMP_GT) begin : g_gt
      assign hit_o = (val_i > lim_i);
    end else if (MODE == CMP_LE) begin : g_le
      assign hit_o = (val_i <= lim_i);
    end else begin : g_ge
      assign hit_o = (val_i >= lim_i);
    end
  endgenerate

endmodule

// File: rtl/therm_sync.sv
module therm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/therm_flag.sv
module therm_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);

  // set wins over a simultaneous clear
  assign nxt_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end

endmodule

// File: rtl/therm_rearm.sv
module therm_rearm #(
  parameter int W    = 8,
  parameter int HYST = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic signed [W-1:0] temp_i,
  input  logic signed [W-1:0] lim_i,
  input  logic                disarm_i,
  output logic                armed_o
);

  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] HYST_X = XW'(HYST);

  logic signed [XW-1:0] temp_x, thr_x;
  logic                 cooled;

  assign temp_x = {{2{temp_i[W-1]}}, temp_i};
  assign thr_x  = {{2{lim_i[W-1]}}, lim_i} - HYST_X;
  assign cooled = (temp_x <= thr_x);

  always_ff @(posedge clk) begin
    if (rst)                   armed_o <= 1'b1;
    else if (tick_i && cooled) armed_o <= 1'b1;
    else if (disarm_i)         armed_o <= 1'b0;
  end

endmodule

// File: rtl/therm_status_reg.sv
module therm_status_reg
  import therm_stat_pkg::*;
#(
  parameter int TW          = 8,
  parameter int HYST_DEG    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mon_tick,
  input  logic signed [TW-1:0] temp_local,
  input  logic signed [TW-1:0] temp_remote,
  input  logic signed [TW-1:0] temp_active,
  input  logic signed [TW-1:0] lim_therm,
  input  logic signed [TW-1:0] lim_passive,
  input  logic signed [TW-1:0] lim_crit_local,
  input  logic signed [TW-1:0] lim_crit_remote,
  input  logic                 ext_therm_n,
  input  logic                 en_therm_irq,
  input  logic                 en_passive_irq,
  input  logic                 rd_self,
  input  logic                 rd_peer,
  output logic [7:0]           rd_data,
  output logic                 therm_pin_n,
  output logic                 ovr_pin_n,
  output logic                 alert_n
);

  // comparator bank
  logic signed [TW-1:0] cmp_val [NUM_CMP];
  logic signed [TW-1:0] cmp_lim [NUM_CMP];
  logic [NUM_CMP-1:0]   cmp_hit;

  assign cmp_val[0] = temp_local;   assign cmp_lim[0] = lim_therm;
  assign cmp_val[1] = temp_active;  assign cmp_lim[1] = lim_passive;
  assign cmp_val[2] = temp_local;   assign cmp_lim[2] = lim_crit_local;
  assign cmp_val[3] = temp_remote;  assign cmp_lim[3] = lim_crit_remote;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    therm_cmp #(.W(TW), .MODE(slot_mode(i))) u_cmp (
      .val_i (cmp_val[i]),
      .lim_i (cmp_lim[i]),
      .hit_o (cmp_hit[i])
    );
  end

  // external request synchronizer
  logic ext_sync_n;

  therm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_therm_n),
    .dout (ext_sync_n)
  );

  // set / clear terms per status bit
  logic [STAT_W-1:0] flag_set, flag_clr, flag_nxt, flag_q;
  logic              armed, disarm;

  always_comb begin
    flag_set = '0;
    flag_clr = '0;
    flag_set[BIT_EXT] = ~ext_sync_n;
    flag_clr[BIT_EXT] = rd_self;
    for (int s = 0; s < NUM_CMP; s++) begin
      flag_set[slot_bit(s)] = mon_tick & cmp_hit[s];
      flag_clr[slot_bit(s)] = rd_self;
    end
    // limit flag: gated by re-arm, cleared by the companion read
    flag_set[BIT_OVERLIM] = mon_tick & cmp_hit[0] & armed;
    flag_clr[BIT_OVERLIM] = rd_peer;
  end

  for (genvar b = BIT_CRITREM; b < STAT_W; b++) begin : g_flag
    therm_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (flag_set[b]),
      .clr_i (flag_clr[b]),
      .nxt_o (flag_nxt[b]),
      .q_o   (flag_q[b])
    );
  end

  for (genvar r = 0; r < BIT_CRITREM; r++) begin : g_rsvd
    assign flag_nxt[r] = 1'b0;
    assign flag_q[r]   = 1'b0;
  end

  // a clear that actually takes the flag down disarms it
  assign disarm = flag_q[BIT_OVERLIM] & ~flag_nxt[BIT_OVERLIM];

  therm_rearm #(.W(TW), .HYST(HYST_DEG)) u_rearm (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (mon_tick),
    .temp_i   (temp_local),
    .lim_i    (lim_therm),
    .disarm_i (disarm),
    .armed_o  (armed)
  );

  assign rd_data = flag_q;

  // pins, registered from the next flag state so they align with rd_data
  logic alert_src;

  assign alert_src = (flag_nxt[BIT_OVERLIM] & en_therm_irq)
                   | (flag_nxt[BIT_PASSIVE] & en_passive_irq)
                   |  flag_nxt[BIT_CRITLOC]
                   |  flag_nxt[BIT_CRITREM];

  always_ff @(posedge clk) begin
    if (rst) begin
      therm_pin_n <= 1'b1;
      ovr_pin_n   <= 1'b1;
      alert_n     <= 1'b1;
    end else begin
      therm_pin_n <= ~flag_nxt[BIT_OVERLIM];
      ovr_pin_n   <= ~(flag_nxt[BIT_CRITLOC] | flag_nxt[BIT_CRITREM]);
      alert_n     <= ~alert_src;
    end
  end

endmodule

// File: rtl/therm_status_chk.sv
module therm_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       mon_tick,
  input logic       rd_self,
  input logic       rd_peer,
  input logic [7:0] rd_data,
  input logic       therm_pin_n,
  input logic       ovr_pin_n,
  input logic       alert_n
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == 8'h00 && therm_pin_n && ovr_pin_n && alert_n));

  // R4
  a_r4_pin_follows_flag: assert property (@(posedge clk) disable iff (rst)
    therm_pin_n == !rd_data[6]);

  // R8
  a_r8_ovr_follows_crit: assert property (@(posedge clk) disable iff (rst)
    ovr_pin_n == !(rd_data[4] || rd_data[3]));

  // R11
  a_r11_crit_alerts: assert property (@(posedge clk) disable iff (rst)
    (rd_data[4] || rd_data[3]) |-> !alert_n);

  // R5
  a_r5_limit_sticky: assert property (@(posedge clk) disable iff (rst)
    (rd_data[6] && !rd_peer) |=> rd_data[6]);

  // R9
  a_r9_self_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_self && !mon_tick) |=> (rd_data[5:3] == 3'b000 && !rd_data[7] || rd_data[7]));

  // R10
  a_r10_no_set_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!mon_tick && rd_data[5:3] == 3'b000) |=> (rd_data[5:3] == 3'b000));

endmodule

bind therm_status_reg therm_status_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mon_tick    (mon_tick),
  .rd_self     (rd_self),
  .rd_peer     (rd_peer),
  .rd_data     (rd_data),
  .therm_pin_n (therm_pin_n),
  .ovr_pin_n   (ovr_pin_n),
  .alert_n     (alert_n)
);

// File: tb/sim_therm_status_reg.sv
module sim_therm_status_reg;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mon_tick = 1'b0;
  logic signed [7:0] temp_local = 8'sd0, temp_remote = 8'sd0, temp_active = 8'sd0;
  logic signed [7:0] lim_therm = 8'sd100, lim_passive = -8'sd128;
  logic signed [7:0] lim_crit_local = 8'sd127, lim_crit_remote = 8'sd127;
  logic ext_therm_n = 1'b1;
  logic en_therm_irq = 1'b0, en_passive_irq = 1'b0;
  logic rd_self = 1'b0, rd_peer = 1'b0;
  logic [7:0] rd_data;
  logic therm_pin_n, ovr_pin_n, alert_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  therm_status_reg u0 (
    .clk(clk), .rst(rst), .mon_tick(mon_tick),
    .temp_local(temp_local), .temp_remote(temp_remote), .temp_active(temp_active),
    .lim_therm(lim_therm), .lim_passive(lim_passive),
    .lim_crit_local(lim_crit_local), .lim_crit_remote(lim_crit_remote),
    .ext_therm_n(ext_therm_n), .en_therm_irq(en_therm_irq),
    .en_passive_irq(en_passive_irq), .rd_self(rd_self), .rd_peer(rd_peer),
    .rd_data(rd_data), .therm_pin_n(therm_pin_n), .ovr_pin_n(ovr_pin_n),
    .alert_n(alert_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    mon_tick = 1'b1; cyc(); mon_tick = 1'b0;
  endtask

  task automatic read_self();
    rd_self = 1'b1; cyc(); rd_self = 1'b0;
  endtask

  task automatic read_peer();
    rd_peer = 1'b1; cyc(); rd_peer = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(2);
    chk("R1 status", rd_data, 8'h00);
    chk("R1 pins", {5'b0, therm_pin_n, ovr_pin_n, alert_n}, 8'h07);
    rst = 1'b0; cyc();
  endtask

  task automatic t_ext();
    ext_therm_n = 1'b0; cyc();
    chk("R2 synchronizer delay", rd_data, 8'h00);
    cyc(2);
    chk("R2 bit7 set", rd_data, 8'h80);
    chk("R11 bit7 no alert", {7'b0, alert_n}, 8'h01);
    ext_therm_n = 1'b1; cyc(4);
    chk("R2 bit7 sticky", rd_data, 8'h80);
    read_peer();
    chk("R3 peer read keeps bit7", rd_data, 8'h80);
    read_self();
    chk("R3 self read clears bit7", rd_data, 8'h00);
  endtask

  task automatic t_limit();
    lim_therm = 8'sd50; temp_local = 8'sd50; tick();
    chk("R4 equality no set", {rd_data[7:6], 5'b0, therm_pin_n}, 8'h01);
    temp_local = 8'sd51; tick();
    chk("R4 over limit sets", {rd_data[7:6], 5'b0, therm_pin_n}, 8'h40);
    chk("R11 masked limit", {7'b0, alert_n}, 8'h01);
    en_therm_irq = 1'b1; cyc();
    chk("R11 enabled limit", {7'b0, alert_n}, 8'h00);
    en_therm_irq = 1'b0; cyc();
    read_self();
    chk("R5 self read keeps bit6", rd_data, 8'h40);
    read_peer();
    chk("R5 peer read clears bit6", rd_data, 8'h00);
    tick();
    chk("R6 no reassert while hot", rd_data, 8'h00);
    temp_local = 8'sd46; tick(); temp_local = 8'sd51; tick();
    chk("R6 4C drop not enough", rd_data, 8'h00);
    temp_local = 8'sd45; tick();
    chk("R6 rearm tick no set", rd_data, 8'h00);
    temp_local = 8'sd51; tick();
    chk("R6 set after rearm", rd_data, 8'h40);
    rd_peer = 1'b1; mon_tick = 1'b1; cyc(); rd_peer = 1'b0; mon_tick = 1'b0;
    chk("R12 peer read with set", rd_data, 8'h40);
    read_peer();
    temp_local = 8'sd0; tick();
    lim_therm = 8'sd100; cyc();
  endtask

  task automatic t_passive();
    lim_passive = 8'sd10; temp_active = 8'sd10; tick();
    chk("R7 at threshold sets", rd_data, 8'h20);
    chk("R11 masked passive", {7'b0, alert_n}, 8'h01);
    en_passive_irq = 1'b1; cyc();
    chk("R11 enabled passive", {7'b0, alert_n}, 8'h00);
    en_passive_irq = 1'b0;
    read_self();
    chk("R7 self read clears", rd_data, 8'h00);
    tick();
    chk("R7 reasserts next tick", rd_data, 8'h20);
    rd_self = 1'b1; mon_tick = 1'b1; #1;
    chk("R12 read shows held value", rd_data, 8'h20);
    cyc(); rd_self = 1'b0; mon_tick = 1'b0;
    chk("R12 set wins over clear", rd_data, 8'h20);
    temp_active = 8'sd11; read_self(); tick();
    chk("R7 above threshold no set", rd_data, 8'h00);
    lim_passive = -8'sd128; temp_active = 8'sd0; cyc();
  endtask

  task automatic t_crit();
    lim_crit_local = 8'sd60; temp_local = 8'sd60; tick();
    chk("R8 local crit sets", {rd_data[7:3], 2'b0, ovr_pin_n}, 8'h10);
    chk("R11 crit alert unmasked", {7'b0, alert_n}, 8'h00);
    read_self();
    chk("R9 self read clears bit4", {rd_data[7:3], 2'b0, ovr_pin_n}, 8'h01);
    tick();
    chk("R9 bit4 reasserts", rd_data, 8'h10);
    temp_local = 8'sd0; read_self(); tick();
    chk("R9 gone after condition ends", rd_data, 8'h00);
    lim_crit_local = 8'sd127;
    lim_crit_remote = 8'sd20; temp_remote = 8'sd25; tick();
    chk("R8 remote crit sets", {rd_data[7:3], 2'b0, ovr_pin_n}, 8'h08);
    read_self();
    chk("R9 self read clears bit3", rd_data, 8'h00);
    lim_crit_remote = 8'sd127; temp_remote = 8'sd0; cyc();
  endtask

  task automatic t_no_tick();
    lim_crit_local = 8'sd0; temp_local = 8'sd5; cyc(5);
    chk("R10 no set without tick", rd_data, 8'h00);
    tick();
    chk("R10 set on tick", rd_data, 8'h10);
    lim_crit_local = 8'sd127; temp_local = 8'sd0; read_self();
  endtask

  task automatic t_signed();
    lim_crit_remote = 8'sd10; temp_remote = -8'sd20; tick();
    chk("R13 negative below positive", rd_data, 8'h00);
    lim_crit_local = -8'sd5; temp_local = -8'sd3; tick();
    chk("R13 negative compare sets", rd_data, 8'h10);
    chk("R1 low bits zero", {5'b0, rd_data[2:0]}, 8'h00);
    lim_crit_local = 8'sd127; lim_crit_remote = 8'sd127;
    temp_local = 8'sd0; temp_remote = 8'sd0; read_self();
  endtask

  initial begin
    t_reset();
    t_ext();
    t_limit();
    t_passive();
    t_crit();
    t_no_tick();
    t_signed();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule